// File: doc/BRIEF.md
# Subcode Symbol Extractor

This block pulls compact-disc style subcode symbols out of the user-bit stream of a consumer digital audio link. It receives one user bit at a time, qualified by a valid strobe, from a subframe decoder upstream. It takes all of its timing from the content of that stream. A long run of zero bits marks the start of a block. Each symbol then opens with a one-valued start bit, followed by seven data bits that carry channels Q to W. The spacing between symbols may vary, and there is no free-running divider.

Each start bit produces a frame-sync pulse. A start bit that follows the long zero run also produces a block-sync pulse. Each completed symbol is placed in a parallel register and marked by a one-cycle valid pulse. The same symbol is loaded into a serial shifter, which an external bit clock steps out MSB first. The block reports whether it has seen its first block sync. It also checks that each block held close to the nominal 98 symbols.

Top module: `subcode_extractor`

## Requirements
- R1: A zero-run counter counts consecutive valid zero user bits and clears on a valid one bit. It saturates at ZRUN_MIN (22). Data bits and gap bits both count.
- R2: A valid one bit in the gap state is a start bit. When at least 22 zero bits came directly before it, `bsync` goes high on the next cycle and stays high for BSYNC_CYC (16) cycles. After only 21 zeros, no block sync occurs.
- R3: After a start bit, exactly the next 7 valid bits are captured. The first of them lands in `symbol[6]` and the last in `symbol[0]`. `sym_vld` pulses for one cycle, in the cycle after the 7th valid bit.
- R4: Valid zero bits in the gap state are ignored: they cause no `sym_vld` and leave `symbol` unchanged. `ubit` has no effect while `ubit_vld` is low.
- R5: Every start bit raises `fsync` on the next cycle for FSYNC_CYC (8) cycles.
- R6: `unlocked` is high from reset until the first block start. It falls together with the rise of `bsync` and stays low after that.
- R7: At each block start after lock, `blk_err` pulses for one cycle together with the rise of `bsync` if the previous block held fewer than 96 or more than 100 completed symbols (SYM_NOM 98 ± SYM_TOL 2).
- R8: `symbol` holds its value in every cycle in which `sym_vld` is low.
- R9: `sdo` shows `symbol[6]` once a symbol is loaded. Each rising edge of `sclk` shifts the next lower bit to `sdo`, with a delay of three clock cycles after the edge. After 7 shifts, `sdo` is 0. The shifter reloads on each `sym_vld`.
- R10: While `rst_n` is low, all outputs are 0 except `unlocked`, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ubit_vld | input | 1 | User bit strobe |
| ubit | input | 1 | User bit value |
| sclk | input | 1 | External serial shift clock (asynchronous) |
| bsync | output | 1 | Block sync pulse |
| fsync | output | 1 | Symbol sync pulse |
| sym_vld | output | 1 | One-cycle pulse when a symbol is completed |
| symbol | output | 7 | Last completed symbol, Q in bit 6 and W in bit 0 |
| sdo | output | 1 | Serial symbol data, MSB first |
| unlocked | output | 1 | High until the first block sync |
| blk_err | output | 1 | Symbol count per block out of the allowed window |

## Verification
The assertions check the following on every cycle:
- the zero counter clears on a one bit and never exceeds its limit;
- the symbol register is stable whenever no valid pulse is present;
- a block sync always comes with a frame sync;
- the lock flag falls only at a block sync and never rises again;
- an error pulse appears only at a block sync;
- the shift register moves only on a load or a synchronised clock edge.

Some behaviours can only be shown by the bench's scenarios. These are the exact 21 versus 22 zero threshold, the bit order of captured symbols under random gaps, the pulse widths, the count window edges (95, 100 and 101 symbols), and the serial bit sequence.

// File: rtl/subcode_pkg.sv
package subcode_pkg;
  typedef enum logic {
    FR_GAP  = 1'b0,
    FR_DATA = 1'b1
  } framer_state_e;
endpackage

// File: rtl/zero_run_det.sv
module zero_run_det #(
  parameter int ZRUN_MIN = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_val,
  output logic run_ok
);
  localparam int ZW = $clog2(ZRUN_MIN + 1);
  localparam logic [ZW-1:0] ZMAX = ZW'(ZRUN_MIN);

  logic [ZW-1:0] zrun_q, zrun_d;

  always_comb begin
    zrun_d = zrun_q;
    if (bit_vld) begin
      if (bit_val)            zrun_d = '0;
      else if (zrun_q != ZMAX) zrun_d = zrun_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zrun_q <= '0;
    else        zrun_q <= zrun_d;
  end

  assign run_ok = (zrun_q == ZMAX);

  // R1: a one bit clears the run
  p_clear_on_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && bit_val) |=> (zrun_q == '0));
  // R1: saturation
  p_saturate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    zrun_q <= ZMAX);
endmodule

// File: rtl/pulse_stretch.sv
module pulse_stretch #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  generate
    if (LEN == 1) begin : g_single
      logic p_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= 1'b0;
        else        p_q <= trig;
      end
      assign pulse = p_q;
    end else begin : g_count
      localparam int CW = $clog2(LEN + 1);
      logic [CW-1:0] cnt_q, cnt_d;
      always_comb begin
        cnt_d = cnt_q;
        if (trig)               cnt_d = CW'(LEN);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
      assign pulse = (cnt_q != '0);
    end
  endgenerate

  // R5: a trigger always yields a high output next cycle
  p_trig_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> pulse);
endmodule

// File: rtl/subcode_framer.sv
module subcode_framer
  import subcode_pkg::*;
#(
  parameter int DATA_BITS = 7,
  parameter int SYM_NOM   = 98,
  parameter int SYM_TOL   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_vld,
  input  logic                 bit_val,
  input  logic                 run_ok,
  output logic                 start_o,
  output logic                 blk_start_o,
  output logic                 load_o,
  output logic [DATA_BITS-1:0] load_data_o,
  output logic [DATA_BITS-1:0] sym_o,
  output logic                 sym_vld_o,
  output logic                 unlocked_o,
  output logic                 blk_err_o
);
  localparam int BW = $clog2(DATA_BITS);
  localparam int CW = $clog2(SYM_NOM + SYM_TOL + 2);
  localparam logic [BW-1:0] LAST   = BW'(DATA_BITS - 1);
  localparam logic [CW-1:0] CNT_LO = CW'(SYM_NOM - SYM_TOL);
  localparam logic [CW-1:0] CNT_HI = CW'(SYM_NOM + SYM_TOL);
  localparam logic [CW-1:0] CNT_MX = CW'(SYM_NOM + SYM_TOL + 1);

  framer_state_e          st_q, st_d;
  logic [BW-1:0]          bcnt_q, bcnt_d;
  logic [DATA_BITS-2:0]   sh_q, sh_d;
  logic [DATA_BITS-1:0]   sym_q, sym_d;
  logic                   vld_q, vld_d;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   lock_q, lock_d;
  logic                   err_q, err_d;
  logic                   start, blk, done;

  always_comb begin
    st_d   = st_q;
    bcnt_d = bcnt_q;
    sh_d   = sh_q;
    sym_d  = sym_q;
    vld_d  = 1'b0;
    cnt_d  = cnt_q;
    lock_d = lock_q;
    err_d  = 1'b0;
    start  = 1'b0;
    blk    = 1'b0;
    done   = 1'b0;
    if (bit_vld) begin
      case (st_q)
        FR_GAP: begin
          if (bit_val) begin
            start  = 1'b1;
            st_d   = FR_DATA;
            bcnt_d = '0;
            if (run_ok) begin
              blk    = 1'b1;
              lock_d = 1'b1;
              err_d  = lock_q && ((cnt_q < CNT_LO) || (cnt_q > CNT_HI));
              cnt_d  = '0;
            end
          end
        end
        default: begin
          sh_d   = {sh_q[DATA_BITS-3:0], bit_val};
          bcnt_d = bcnt_q + 1'b1;
          if (bcnt_q == LAST) begin
            done  = 1'b1;
            sym_d = {sh_q, bit_val};
            vld_d = 1'b1;
            st_d  = FR_GAP;
            if (cnt_q != CNT_MX) cnt_d = cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_GAP;
      bcnt_q <= '0;
      sh_q   <= '0;
      sym_q  <= '0;
      vld_q  <= 1'b0;
      cnt_q  <= '0;
      lock_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      bcnt_q <= bcnt_d;
      sh_q   <= sh_d;
      sym_q  <= sym_d;
      vld_q  <= vld_d;
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
      err_q  <= err_d;
    end
  end

  assign start_o     = start;
  assign blk_start_o = blk;
  assign load_o      = done;
  assign load_data_o = {sh_q, bit_val};
  assign sym_o       = sym_q;
  assign sym_vld_o   = vld_q;
  assign unlocked_o  = !lock_q;
  assign blk_err_o   = err_q;

  // R3: a symbol is only completed by an accepted bit
  p_vld_from_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sym_vld_o |-> $past(bit_vld));
  // R8: register holds between completions
  p_sym_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_vld_o |-> $stable(sym_o));
  // R6: lock never drops
  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked_o |=> !unlocked_o);
endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_i,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic         sdo_o
);
  logic [2:0]   sync_q;
  logic [W-1:0] sreg_q, sreg_d;
  logic         rise;

  assign rise = sync_q[1] && !sync_q[2];

  always_comb begin
    sreg_d = sreg_q;
    if (load_i)    sreg_d = data_i;
    else if (rise) sreg_d = {sreg_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      sreg_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], sclk_i};
      sreg_q <= sreg_d;
    end
  end

  assign sdo_o = sreg_q[W-1];

  // R9: shifter moves only on a load or a clock edge
  p_shift_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !rise) |=> $stable(sreg_q));
endmodule

// File: rtl/subcode_extractor.sv
module subcode_extractor #(
  parameter int ZRUN_MIN  = 22,
  parameter int DATA_BITS = 7,
  parameter int SYM_NOM   = 98,
  parameter int SYM_TOL   = 2,
  parameter int FSYNC_CYC = 8,
  parameter int BSYNC_CYC = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ubit_vld,
  input  logic                 ubit,
  input  logic                 sclk,
  output logic                 bsync,
  output logic                 fsync,
  output logic                 sym_vld,
  output logic [DATA_BITS-1:0] symbol,
  output logic                 sdo,
  output logic                 unlocked,
  output logic                 blk_err
);
  logic                 run_ok, start, blk_start, load;
  logic [DATA_BITS-1:0] load_data;

  zero_run_det #(.ZRUN_MIN(ZRUN_MIN)) u_zrun (
    .clk(clk), .rst_n(rst_n), .bit_vld(ubit_vld), .bit_val(ubit), .run_ok(run_ok)
  );

  subcode_framer #(.DATA_BITS(DATA_BITS), .SYM_NOM(SYM_NOM), .SYM_TOL(SYM_TOL)) u_frm (
    .clk(clk), .rst_n(rst_n), .bit_vld(ubit_vld), .bit_val(ubit), .run_ok(run_ok),
    .start_o(start), .blk_start_o(blk_start), .load_o(load), .load_data_o(load_data),
    .sym_o(symbol), .sym_vld_o(sym_vld), .unlocked_o(unlocked), .blk_err_o(blk_err)
  );

  pulse_stretch #(.LEN(FSYNC_CYC)) u_fsync (
    .clk(clk), .rst_n(rst_n), .trig(start), .pulse(fsync)
  );

  pulse_stretch #(.LEN(BSYNC_CYC)) u_bsync (
    .clk(clk), .rst_n(rst_n), .trig(blk_start), .pulse(bsync)
  );

  ser_shift #(.W(DATA_BITS)) u_ser (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .load_i(load), .data_i(load_data), .sdo_o(sdo)
  );

  // R2: block sync starts together with a frame sync
  p_bsync_with_fsync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bsync) |-> $rose(fsync));
  // R6: lock is gained only at a block start
  p_lock_at_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unlocked) |-> $rose(bsync));
  // R7: count error only at a block start
  p_err_at_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    blk_err |-> $rose(bsync));
endmodule

// File: tb/tb_subcode_extractor.sv
`timescale 1ns/1ps
module tb_subcode_extractor;
  logic       clk = 1'b0;
  logic       rst_n, ubit_vld, ubit, sclk;
  logic       bsync, fsync, sym_vld, sdo, unlocked, blk_err;
  logic [6:0] symbol;

  int checks = 0;
  int errors = 0;
  int zrun_m = 0;
  int cnt_m = 0;
  bit locked_m = 0;
  logic [6:0] prev_sym = '0;
  int run_f = 0;
  int run_b = 0;

  always #4 clk = ~clk;

  subcode_extractor dut (
    .clk(clk), .rst_n(rst_n), .ubit_vld(ubit_vld), .ubit(ubit), .sclk(sclk),
    .bsync(bsync), .fsync(fsync), .sym_vld(sym_vld), .symbol(symbol), .sdo(sdo),
    .unlocked(unlocked), .blk_err(blk_err)
  );

  function automatic void check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endfunction

  // pulse width monitors (R5, R2)
  always @(negedge clk) begin
    if (rst_n) begin
      if (fsync) run_f++;
      else if (run_f > 0) begin check(run_f == 8, "R5 fsync width", run_f, 8); run_f = 0; end
      if (bsync) run_b++;
      else if (run_b > 0) begin check(run_b == 16, "R2 bsync width", run_b, 16); run_b = 0; end
    end
  end

  task automatic send_bit(input bit b);
    @(negedge clk);
    ubit_vld = 1'b1;
    ubit     = b;
    @(negedge clk);
    ubit_vld = 1'b0;
    ubit     = 1'($urandom);
    if (b) zrun_m = 0; else zrun_m++;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_symbol(input logic [6:0] s, input int ngap);
    bit exp_bs, exp_err;
    exp_bs  = (zrun_m >= 22);
    exp_err = exp_bs && locked_m && ((cnt_m < 96) || (cnt_m > 100));
    send_bit(1'b1);
    check(fsync == 1'b1, "R5 fsync on start", int'(fsync), 1);
    check(bsync == exp_bs, "R2 bsync at start", int'(bsync), int'(exp_bs));
    check(blk_err == exp_err, "R7 blk_err", int'(blk_err), int'(exp_err));
    if (exp_bs) begin locked_m = 1; cnt_m = 0; end
    check(unlocked == !locked_m, "R6 unlocked", int'(unlocked), int'(!locked_m));
    idle(2);
    for (int i = 6; i >= 0; i--) begin
      send_bit(s[i]);
      if (i > 0) check(sym_vld == 1'b0, "R3 early valid", int'(sym_vld), 0);
      idle(2);
    end
    cnt_m++;
    prev_sym = s;
    for (int g = 0; g < ngap; g++) begin
      send_bit(1'b0);
      check(sym_vld == 1'b0 && symbol == prev_sym, "R4 gap ignored", int'(symbol), int'(prev_sym));
      idle(2);
    end
  endtask

  task automatic check_last(input logic [6:0] s);
    // called right after send_symbol with ngap == 0 is too late for sym_vld; use sticky value
    check(symbol == s, "R3 symbol value", int'(symbol), int'(s));
  endtask

  task automatic pad_to(input int n);
    while (zrun_m < n) begin send_bit(1'b0); idle(2); end
  endtask

  task automatic run_syms(input int n);
    for (int k = 0; k < n; k++) begin
      logic [6:0] s;
      s = 7'($urandom);
      send_symbol(s, int'($urandom_range(0, 3)));
      check_last(s);
    end
  endtask

  // capture the sym_vld pulse timing on a directed symbol
  task automatic directed_symbol(input logic [6:0] s);
    send_bit(1'b1); idle(2);
    for (int i = 6; i >= 0; i--) begin
      send_bit(s[i]);
      if (i == 0) begin
        check(sym_vld == 1'b1, "R3 valid after 7th bit", int'(sym_vld), 1);
        check(symbol == s, "R3 captured symbol", int'(symbol), int'(s));
        @(negedge clk);
        check(sym_vld == 1'b0, "R3 valid one cycle", int'(sym_vld), 0);
        idle(1);
      end else idle(2);
    end
    cnt_m++;
    prev_sym = s;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; ubit_vld = 1'b0; ubit = 1'b0; sclk = 1'b0;
    idle(3);
    check(bsync == 0 && fsync == 0 && sym_vld == 0 && blk_err == 0, "R10 reset pulses", int'({bsync, fsync, sym_vld, blk_err}), 0);
    check(symbol == 0 && sdo == 0, "R10 reset data", int'({symbol, sdo}), 0);
    check(unlocked == 1'b1, "R10 reset unlocked", int'(unlocked), 1);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // unlocked extraction with random gaps
    run_syms(3);
    // valid low: ubit toggling must do nothing (R4)
    for (int t = 0; t < 20; t++) begin ubit = ~ubit; @(negedge clk); end
    check(sym_vld == 0 && symbol == prev_sym && fsync == 0, "R4 ubit ignored when invalid", int'(symbol), int'(prev_sym));

    // 21 zeros: no block sync (R1, R2)
    pad_to(21);
    send_symbol(7'h55, 1);
    check(unlocked == 1'b1, "R1 21 zeros no lock", int'(unlocked), 1);
    // 22 zeros: block start
    pad_to(22);
    check(zrun_m == 22, "R1 model run", zrun_m, 22);
    send_bit(1'b1);
    check(bsync == 1 && fsync == 1, "R2 block start at 22", int'(bsync), 1);
    check(unlocked == 0, "R6 lock at first block", int'(unlocked), 0);
    check(blk_err == 0, "R7 no error first block", int'(blk_err), 0);
    locked_m = 1; cnt_m = 0;
    // finish symbol directed, checking valid pulse timing
    idle(2);
    begin
      logic [6:0] s = 7'b1011001;
      for (int i = 6; i >= 0; i--) begin
        send_bit(s[i]);
        if (i == 0) begin
          check(sym_vld == 1'b1, "R3 valid after 7th bit", int'(sym_vld), 1);
          check(symbol == s, "R3 captured symbol", int'(symbol), int'(s));
          @(negedge clk);
          check(sym_vld == 1'b0, "R3 valid one cycle", int'(sym_vld), 0);
          idle(1);
        end else idle(2);
      end
      cnt_m++;
      prev_sym = s;
      // serial shift-out (R9) with symbol stability (R8)
      idle(20);
      for (int k = 6; k >= 0; k--) begin
        check(sdo == s[k], "R9 serial bit", int'(sdo), int'(s[k]));
        sclk = 1'b1; idle(5);
        sclk = 1'b0; idle(5);
      end
      check(sdo == 1'b0, "R9 zero after seven shifts", int'(sdo), 0);
      check(symbol == s, "R8 symbol stable during shift", int'(symbol), int'(s));
    end

    // blocks of various lengths: 98 total, 95, 100, 101, 5
    run_syms(97);
    pad_to(22 + int'($urandom_range(0, 4)));
    run_syms(95);
    pad_to(22);
    run_syms(100);
    pad_to(23);
    run_syms(101);
    pad_to(22);
    directed_symbol(7'h7F);
    run_syms(4);
    pad_to(22);
    run_syms(96);
    pad_to(22);
    run_syms(1);
    idle(40);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule